// File: doc/BRIEF.md
# Single-Buffer Serial DMA Channel

This block moves one software-described buffer between memory and a serial engine's byte stream. Software writes a 64-bit buffer pointer as two 32-bit halves, an optional attribute word and then a byte length. The length write arms the channel. In transmit form, the channel reads 32-bit words from a simple memory port and sends their bytes on a valid/ready output stream. In receive form, it collects bytes from a valid/ready input stream, packs them into words and writes them to memory with byte strobes.

Three interrupt sources are kept: done, end-of-transfer and bus error. Their status bits are cleared by writing ones. Their enables can only be changed through a set register and a clear register. The receive form also has a flush command that ends a transfer early, and an option that fills the unused lanes of the last word with zeros. A byte counter reports how many bytes actually moved, so a flushed receive can be measured. The `RX_MODE` parameter selects the direction.

Top module: `sdma_chan`

## Requirements
- R1: After reset the channel is idle (`busy` low, `mem_req` low). Interrupt status (word 4), interrupt enable (word 5) and moved-byte count (word 8) all read zero, and `irq` is low.
- R2: Writing word 6 sets the enable bits written as 1. Writing word 7 clears the enable bits written as 1. Bits written as 0 keep their value in both cases. Word 5 is read-only and shows the resulting enables.
- R3: Status bit 0 is done, bit 1 is end-of-transfer and bit 2 is bus error. Writing ones to word 4 clears the matching bits, and writing all ones clears every bit. An event in the same cycle as a clear wins. `irq` is high exactly when some status bit and its enable are both 1.
- R4: Word 0 holds the low pointer half and word 1 holds the high half. Memory accesses use the address {high, low} with bits 1:0 forced to zero. Successive words go to addresses that rise by 4. `mem_req` and `mem_addr` hold steady until `mem_rsp`.
- R5: In transmit form, a length write (word 3, only when idle) starts the transfer. Exactly that many bytes leave on `tx_data`, in order of ascending address, with lane 0 (bits 7:0) of each word first. Then done is set and word 8 equals the length.
- R6: Transmit attribute bit 0 (word 2) marks the buffer as end-of-transfer. When it is set, end-of-transfer is raised together with done. In receive form, word 2 reads zero and end-of-transfer never rises.
- R7: A length of zero sets done one cycle after the write and makes no memory access.
- R8: An error response stops the channel at once. It sets bus error without done, no further bytes move, and word 8 holds the bytes moved before the error.
- R9: In receive form, accepted bytes fill lanes 0 to 3 of each word in order. Each full word is written with strobe 4'hF. Done is set after the length is reached.
- R10: Configuration bit 0 (word 10, receive only) enables zero padding. The final partial word is then written with strobe 4'hF and zeros in the unfilled lanes. Without it, only the filled lanes are strobed.
- R11: A write to word 9 during a receive ends the transfer. It writes out any partially filled word, sets done, and leaves word 8 at the number of bytes received.
- R12: A length write while the channel is busy is ignored, and the running transfer completes with its original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt line |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 64 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Write byte strobes |
| mem_rsp | input | 1 | Access complete |
| mem_rsp_err | input | 1 | Access failed |
| mem_rdata | input | 32 | Read data, valid with mem_rsp |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit byte accepted |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte accepted |

## Verification
The bench builds two instances with `LEN_W` = 16: one with `RX_MODE` = 0 and one with `RX_MODE` = 1. Both directions, the end-of-transfer attribute, flush and zero padding are therefore covered in one run. With a 16-bit length, random lengths up to 40 bytes cross several word boundaries and end on every lane offset. An error region at address bit 11 lets a transfer fail after some words have already succeeded. The 64-bit pointer is checked against a random high half on every request.

// File: rtl/sdma_chan_pkg.sv
package sdma_chan_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MEM  = 2'd1,
        PH_BYTE = 2'd2
    } phase_e;

    localparam logic [3:0] RA_PTR_LO = 4'd0;
    localparam logic [3:0] RA_PTR_HI = 4'd1;
    localparam logic [3:0] RA_ATTR   = 4'd2;
    localparam logic [3:0] RA_LEN    = 4'd3;
    localparam logic [3:0] RA_STAT   = 4'd4;
    localparam logic [3:0] RA_EN     = 4'd5;
    localparam logic [3:0] RA_EN_SET = 4'd6;
    localparam logic [3:0] RA_EN_CLR = 4'd7;
    localparam logic [3:0] RA_COUNT  = 4'd8;
    localparam logic [3:0] RA_FLUSH  = 4'd9;
    localparam logic [3:0] RA_CFG    = 4'd10;

    localparam int IRQ_N    = 3;
    localparam int IRQ_DONE = 0;
    localparam int IRQ_EOT  = 1;
    localparam int IRQ_ERR  = 2;
endpackage

// File: rtl/sdma_irq_ctrl.sv
module sdma_irq_ctrl #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] ev_i,
    input  logic            wr_clr,
    input  logic            wr_set,
    input  logic            wr_unset,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] stat_o,
    output logic [NSRC-1:0] en_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [NSRC-1:0] stat;
        logic [NSRC-1:0] en;
    } irq_s;

    irq_s q, d;

    always_comb begin
        d = q;
        if (wr_clr)   d.stat = q.stat & ~wdata;
        d.stat = d.stat | ev_i;
        if (wr_set)   d.en = q.en | wdata;
        if (wr_unset) d.en = q.en & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stat_o = q.stat;
    assign en_o   = q.en;
    assign irq_o  = |(q.stat & q.en);

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        assert_event_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ev_i[i] |=> stat_o[i]);
        assert_clear_works_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_clr && wdata[i] && !ev_i[i]) |=> !stat_o[i]);
        assert_enable_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_set && wdata[i]) |=> en_o[i]);
        assert_enable_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!wdata[i] || !(wr_set || wr_unset)) |=> (en_o[i] == $past(en_o[i])));
    end
endmodule

// File: rtl/sdma_chan.sv
module sdma_chan
    import sdma_chan_pkg::*;
#(
    parameter bit RX_MODE = 1'b0,
    parameter int LEN_W   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        busy,
    output logic        mem_req,
    output logic        mem_we,
    output logic [63:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [3:0]  mem_wstrb,
    input  logic        mem_rsp,
    input  logic        mem_rsp_err,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        rx_ready
);
    localparam int LANES = 4;
    localparam int LW    = $clog2(LANES);

    typedef struct packed {
        phase_e           ph;
        logic [63:0]      waddr;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] cnt;
        logic             eot;
        logic [LW-1:0]    lane;
        logic [31:0]      word;
        logic [LANES-1:0] strb;
        logic             last;
        logic             fl;
        logic             pad;
        logic             attr;
        logic [31:0]      plo;
        logic [31:0]      phi;
    } chan_s;

    chan_s q, d;
    logic [IRQ_N-1:0] ev, stat, en;
    logic wr_len, wr_flush;
    logic [LEN_W-1:0] cnt_inc;

    assign wr_len   = reg_we && (reg_addr == RA_LEN);
    assign wr_flush = reg_we && (reg_addr == RA_FLUSH) && RX_MODE;
    assign cnt_inc  = q.cnt + 1'b1;

    always_comb begin
        d         = q;
        ev        = '0;
        tx_valid  = 1'b0;
        tx_data   = q.word[8*q.lane +: 8];
        rx_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = RX_MODE;
        mem_addr  = q.waddr;
        mem_wdata = q.word;
        mem_wstrb = (q.pad && q.last) ? {LANES{1'b1}} : q.strb;

        if (reg_we) begin
            case (reg_addr)
                RA_PTR_LO: d.plo  = reg_wdata;
                RA_PTR_HI: d.phi  = reg_wdata;
                RA_ATTR:   d.attr = RX_MODE ? 1'b0 : reg_wdata[0];
                RA_CFG:    d.pad  = RX_MODE ? reg_wdata[0] : 1'b0;
                default: ;
            endcase
        end

        case (q.ph)
            PH_IDLE: begin
                if (wr_len) begin
                    d.len   = reg_wdata[LEN_W-1:0];
                    d.cnt   = '0;
                    d.eot   = q.attr;
                    d.lane  = '0;
                    d.word  = '0;
                    d.strb  = '0;
                    d.last  = 1'b0;
                    d.fl    = 1'b0;
                    d.waddr = {q.phi, q.plo[31:2], 2'b00};
                    if (reg_wdata[LEN_W-1:0] == '0) begin
                        ev[IRQ_DONE] = 1'b1;
                        ev[IRQ_EOT]  = q.attr;
                    end else begin
                        d.ph = RX_MODE ? PH_BYTE : PH_MEM;
                    end
                end
            end
            PH_MEM: begin
                mem_req = 1'b1;
                if (wr_flush) d.fl = 1'b1;
                if (mem_rsp) begin
                    if (mem_rsp_err) begin
                        ev[IRQ_ERR] = 1'b1;
                        d.ph        = PH_IDLE;
                    end else if (RX_MODE) begin
                        if (q.last || q.fl || wr_flush) begin
                            ev[IRQ_DONE] = 1'b1;
                            d.ph         = PH_IDLE;
                        end else begin
                            d.waddr = q.waddr + 64'd4;
                            d.lane  = '0;
                            d.strb  = '0;
                            d.word  = '0;
                            d.ph    = PH_BYTE;
                        end
                    end else begin
                        d.word = mem_rdata;
                        d.lane = '0;
                        d.ph   = PH_BYTE;
                    end
                end
            end
            PH_BYTE: begin
                if (!RX_MODE) begin
                    tx_valid = 1'b1;
                    if (tx_ready) begin
                        d.cnt = cnt_inc;
                        if (cnt_inc == q.len) begin
                            ev[IRQ_DONE] = 1'b1;
                            ev[IRQ_EOT]  = q.eot;
                            d.ph         = PH_IDLE;
                        end else if (q.lane == LW'(LANES-1)) begin
                            d.waddr = q.waddr + 64'd4;
                            d.ph    = PH_MEM;
                        end else begin
                            d.lane = q.lane + 1'b1;
                        end
                    end
                end else if (wr_flush) begin
                    if (q.strb != '0) begin
                        d.last = 1'b1;
                        d.ph   = PH_MEM;
                    end else begin
                        ev[IRQ_DONE] = 1'b1;
                        d.ph         = PH_IDLE;
                    end
                end else begin
                    rx_ready = 1'b1;
                    if (rx_valid) begin
                        d.word[8*q.lane +: 8] = rx_data;
                        d.strb[q.lane]        = 1'b1;
                        d.cnt                 = cnt_inc;
                        if (cnt_inc == q.len) begin
                            d.last = 1'b1;
                            d.ph   = PH_MEM;
                        end else if (q.lane == LW'(LANES-1)) begin
                            d.ph = PH_MEM;
                        end else begin
                            d.lane = q.lane + 1'b1;
                        end
                    end
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = (q.ph != PH_IDLE);

    sdma_irq_ctrl #(.NSRC(IRQ_N)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_i    (ev),
        .wr_clr  (reg_we && (reg_addr == RA_STAT)),
        .wr_set  (reg_we && (reg_addr == RA_EN_SET)),
        .wr_unset(reg_we && (reg_addr == RA_EN_CLR)),
        .wdata   (reg_wdata[IRQ_N-1:0]),
        .stat_o  (stat),
        .en_o    (en),
        .irq_o   (irq)
    );

    always_comb begin
        case (reg_addr)
            RA_PTR_LO: reg_rdata = q.plo;
            RA_PTR_HI: reg_rdata = q.phi;
            RA_ATTR:   reg_rdata = {31'd0, q.attr};
            RA_LEN:    reg_rdata = 32'(q.len);
            RA_STAT:   reg_rdata = 32'(stat);
            RA_EN:     reg_rdata = 32'(en);
            RA_COUNT:  reg_rdata = 32'(q.cnt);
            RA_CFG:    reg_rdata = {31'd0, q.pad};
            default:   reg_rdata = '0;
        endcase
    end

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp) |=> (mem_req && $stable(mem_addr)));
    assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= q.len);
    assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_len && !busy && reg_wdata[LEN_W-1:0] == '0) |=> (!busy && stat[IRQ_DONE]));
    assert_err_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rsp && mem_rsp_err) |=> (!busy && stat[IRQ_ERR]));
    assert_rx_no_eot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        RX_MODE |-> !stat[IRQ_EOT]);
endmodule

// File: tb/tb_sdma_chan.sv
module tb_sdma_chan;
    localparam int LEN_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // transmit instance signals
    logic        t_we = 0;
    logic [3:0]  t_addr = 0;
    logic [31:0] t_wdata = 0, t_rdata;
    logic        t_irq, t_busy, t_req, t_mwe, t_rsp = 0, t_err = 0;
    logic [63:0] t_maddr;
    logic [31:0] t_mwdata, t_mrdata = 0;
    logic [3:0]  t_strb;
    logic        tx_valid, tx_ready = 0;
    logic [7:0]  tx_data;
    logic        t_rxr;

    // receive instance signals
    logic        r_we = 0;
    logic [3:0]  r_addr = 0;
    logic [31:0] r_wdata = 0, r_rdata;
    logic        r_irq, r_busy, r_req, r_mwe, r_rsp = 0, r_err = 0;
    logic [63:0] r_maddr;
    logic [31:0] r_mwdata, r_mrdata = 0;
    logic [3:0]  r_strb;
    logic        r_txv;
    logic [7:0]  r_txd;
    logic        rx_valid = 0, rx_ready;
    logic [7:0]  rx_data = 0;

    sdma_chan #(.RX_MODE(1'b0), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(t_we), .reg_addr(t_addr), .reg_wdata(t_wdata),
        .reg_rdata(t_rdata), .irq(t_irq), .busy(t_busy), .mem_req(t_req), .mem_we(t_mwe),
        .mem_addr(t_maddr), .mem_wdata(t_mwdata), .mem_wstrb(t_strb), .mem_rsp(t_rsp),
        .mem_rsp_err(t_err), .mem_rdata(t_mrdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(1'b0), .rx_data(8'd0), .rx_ready(t_rxr));

    sdma_chan #(.RX_MODE(1'b1), .LEN_W(LEN_W)) dut_rx (
        .clk(clk), .rst_n(rst_n), .reg_we(r_we), .reg_addr(r_addr), .reg_wdata(r_wdata),
        .reg_rdata(r_rdata), .irq(r_irq), .busy(r_busy), .mem_req(r_req), .mem_we(r_mwe),
        .mem_addr(r_maddr), .mem_wdata(r_mwdata), .mem_wstrb(r_strb), .mem_rsp(r_rsp),
        .mem_rsp_err(r_err), .mem_rdata(r_mrdata), .tx_valid(r_txv), .tx_data(r_txd),
        .tx_ready(1'b0), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready));

    int checks = 0, errors = 0, cyc = 0;
    int t_reqs = 0, r_reqs = 0, hi_bad = 0;
    logic [31:0] exp_hi = 0;
    logic [31:0] tmem [0:511];
    logic [31:0] rmem [0:511];
    logic        fill_rx = 0;
    logic [7:0]  rcv [0:4095];
    int          rcv_n = 0;
    logic        sink_hold = 0;

    function automatic logic [7:0] src_byte(input int a);
        return 8'((a * 7 + 3) ^ (a >> 5));
    endfunction
    function automatic logic [7:0] rx_byte(input int n);
        return 8'(n * 13 + 1);
    endfunction

    initial begin
        for (int i = 0; i < 512; i++)
            tmem[i] = {src_byte(4*i+3), src_byte(4*i+2), src_byte(4*i+1), src_byte(4*i)};
    end

    // transmit memory: error region where address bit 11 is set
    always @(posedge clk) begin
        if (!rst_n) t_rsp <= 1'b0;
        else if (t_req && !t_rsp) begin
            t_rsp    <= 1'b1;
            t_err    <= t_maddr[11];
            t_mrdata <= tmem[t_maddr[10:2]];
            t_reqs   <= t_reqs + 1;
            if (t_maddr[63:32] != exp_hi) hi_bad <= hi_bad + 1;
        end else t_rsp <= 1'b0;
    end

    always @(posedge clk) begin
        if (fill_rx) begin
            for (int i = 0; i < 512; i++) rmem[i] <= 32'hA5A5A5A5;
        end
        if (!rst_n) r_rsp <= 1'b0;
        else if (r_req && !r_rsp) begin
            r_rsp  <= 1'b1;
            r_err  <= r_maddr[11];
            r_reqs <= r_reqs + 1;
            if (r_mwe && !r_maddr[11]) begin
                for (int b = 0; b < 4; b++)
                    if (r_strb[b]) rmem[r_maddr[10:2]][8*b +: 8] <= r_mwdata[8*b +: 8];
            end
        end else r_rsp <= 1'b0;
    end

    // byte sink, decides ready at the negative edge
    always @(negedge clk) begin
        logic r;
        r = sink_hold ? 1'b0 : (($urandom % 4) != 0);
        tx_ready = r;
        if (tx_valid && r) begin
            rcv[rcv_n % 4096] = tx_data;
            rcv_n = rcv_n + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input bit rx, input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        if (rx) begin r_we = 1; r_addr = a; r_wdata = v; end
        else    begin t_we = 1; t_addr = a; t_wdata = v; end
        @(negedge clk);
        r_we = 0; t_we = 0;
    endtask

    task automatic rd(input bit rx, input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        if (rx) begin r_addr = a; #1 v = r_rdata; end
        else    begin t_addr = a; #1 v = t_rdata; end
    endtask

    task automatic wait_stat(input bit rx, output logic [31:0] v);
        v = 0;
        for (int i = 0; i < 3000 && v == 0; i++) rd(rx, 4'd4, v);
    endtask

    task automatic run_tx(input logic [31:0] lo, input logic [31:0] hi, input int len,
                          input bit eot, input int exp_n, input logic [2:0] exp_st);
        logic [31:0] v;
        int start, r0, ok;
        exp_hi = hi;
        start = rcv_n;
        r0 = t_reqs;
        wr(0, 4'd0, lo);
        wr(0, 4'd1, hi);
        wr(0, 4'd2, {31'd0, eot});
        wr(0, 4'd4, 32'hFFFFFFFF);
        wr(0, 4'd3, len);
        wait_stat(0, v);
        repeat (4) @(negedge clk);
        check("R5/R6/R8 status", v, {29'd0, exp_st});
        check("R5 byte count out", rcv_n - start, exp_n);
        ok = 1;
        for (int k = 0; k < exp_n; k++)
            if (rcv[(start + k) % 4096] !== src_byte(int'({lo[31:2], 2'b00}) + k)) ok = 0;
        check("R4/R5 byte order", ok, 1);
        rd(0, 4'd8, v);
        check("R5/R8 moved count", v, exp_n);
        if (len == 0) check("R7 no access", t_reqs - r0, 0);
        check("R4 pointer high half", hi_bad, 0);
    endtask

    task automatic send_rx(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (($urandom % 3) == 0) begin rx_valid = 0; @(negedge clk); end
            rx_valid = 1;
            rx_data  = rx_byte(i);
            while (!rx_ready) @(negedge clk);
        end
        @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic run_rx(input logic [31:0] lo, input int len, input int nsend,
                          input bit pad, input bit flush);
        logic [31:0] v;
        int exp_n, ok, wa;
        logic [7:0] eb, gb;
        exp_hi = 32'h0000_00C0;
        @(negedge clk); fill_rx = 1; @(negedge clk); fill_rx = 0;
        wr(1, 4'd0, lo);
        wr(1, 4'd1, exp_hi);
        wr(1, 4'd10, {31'd0, pad});
        wr(1, 4'd4, 32'hFFFFFFFF);
        wr(1, 4'd3, len);
        send_rx(nsend);
        if (flush) begin
            repeat (6) @(negedge clk);
            wr(1, 4'd9, 32'd1);
        end
        wait_stat(1, v);
        repeat (4) @(negedge clk);
        exp_n = flush ? nsend : len;
        check(flush ? "R11 done after flush" : "R9 done status", v, 1);
        rd(1, 4'd8, v);
        check(flush ? "R11 count after flush" : "R9 moved count", v, exp_n);
        ok = 1;
        for (int k = 0; k < ((exp_n + 3) / 4) * 4 + 4; k++) begin
            if (k < exp_n) eb = rx_byte(k);
            else if (pad && k < ((exp_n + 3) / 4) * 4) eb = 8'h00;
            else eb = 8'hA5;
            wa = int'(lo[10:2]) + k / 4;
            gb = rmem[wa][8*(k%4) +: 8];
            if (gb !== eb) ok = 0;
        end
        check(pad ? "R10 padded memory image" : "R9/R11 memory image", ok, 1);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int len, r0;
        bit e, p;
        logic [31:0] base;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(0, 4'd4, v); check("R1 status after reset", v, 0);
        rd(0, 4'd5, v); check("R1 enables after reset", v, 0);
        rd(0, 4'd8, v); check("R1 count after reset", v, 0);
        check("R1 idle", {t_busy, t_req, t_irq, r_busy, r_req}, 0);

        // R2 enable set / clear
        wr(0, 4'd6, 32'h5); rd(0, 4'd5, v); check("R2 enable set", v, 5);
        wr(0, 4'd7, 32'h1); rd(0, 4'd5, v); check("R2 enable clear", v, 4);
        wr(0, 4'd6, 32'h0); rd(0, 4'd5, v); check("R2 zero bits keep", v, 4);
        wr(0, 4'd5, 32'h7); rd(0, 4'd5, v); check("R2 enable read-only", v, 4);

        // R6 eot + R3 partial clear and irq masking
        run_tx(32'h0000_0040, 32'h1234_5678, 9, 1'b1, 9, 3'b011);
        check("R3 irq masked", t_irq, 0);
        wr(0, 4'd6, 32'h1); @(negedge clk);
        check("R3 irq enabled", t_irq, 1);
        wr(0, 4'd4, 32'h1); rd(0, 4'd4, v); check("R3 clear one bit", v, 2);
        wr(0, 4'd4, 32'hFFFFFFFF); rd(0, 4'd4, v); check("R3 clear all", v, 0);
        check("R3 irq low after clear", t_irq, 0);

        // R4 unaligned pointer low bits ignored
        run_tx(32'h0000_0102, 32'hDEAD_0001, 7, 1'b0, 7, 3'b001);

        // R7 zero length
        run_tx(32'h0000_0080, 32'h0, 0, 1'b1, 0, 3'b011);

        // R8 error after two good words
        run_tx(32'h0000_07F8, 32'h0, 16, 1'b0, 8, 3'b100);

        // R12 length write while busy
        sink_hold = 1;
        exp_hi = 32'h0;
        r0 = rcv_n;
        wr(0, 4'd0, 32'h0000_0010);
        wr(0, 4'd1, 32'h0);
        wr(0, 4'd2, 32'h0);
        wr(0, 4'd4, 32'hFFFFFFFF);
        wr(0, 4'd3, 32'd8);
        wr(0, 4'd3, 32'd100);
        check("R12 busy during hold", t_busy, 1);
        sink_hold = 0;
        wait_stat(0, v);
        repeat (4) @(negedge clk);
        check("R12 original length kept", rcv_n - r0, 8);
        rd(0, 4'd3, v); check("R12 length register kept", v, 8);

        // random transmit runs
        for (int i = 0; i < 8; i++) begin
            len  = 1 + int'($urandom % 40);
            base = ($urandom % 256) * 4;
            e    = 1'($urandom % 2);
            run_tx(base, $urandom, len, e, len, {1'b0, e, 1'b1});
        end

        // receive: attribute reads zero
        wr(1, 4'd2, 32'h1); rd(1, 4'd2, v); check("R6 rx attribute zero", v, 0);
        run_rx(32'h0000_0100, 7, 7, 1'b0, 1'b0);
        run_rx(32'h0000_0200, 7, 7, 1'b1, 1'b0);
        run_rx(32'h0000_0300, 20, 6, 1'b0, 1'b1);
        run_rx(32'h0000_0300, 20, 6, 1'b1, 1'b1);
        run_rx(32'h0000_0040, 20, 8, 1'b0, 1'b1);
        r0 = r_reqs;
        run_rx(32'h0000_0040, 0, 0, 1'b0, 1'b0);
        check("R7 rx zero length no access", r_reqs - r0, 0);
        for (int i = 0; i < 5; i++) begin
            len  = 1 + int'($urandom % 30);
            base = ($urandom % 200) * 4;
            p    = 1'($urandom % 2);
            run_rx(base, len, len, p, 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule